// File: doc/BRIEF.md
# Event Timer with One-Shot and Periodic Comparators

The block is a free-running event timer. A 64-bit main counter advances by one on every clock cycle in which the external `tick` input is high and the global run bit is set. Three comparator channels watch the counter. Each channel raises a status bit when the counter reaches its target, and drives an interrupt line when that channel's interrupt enable is set. Software reaches the block through a simple 32-bit register bus: a write strobe with address and data, and a read path that returns data in the same cycle for the address presented.

Every channel runs in one of two modes. In one-shot mode the target is only ever changed by software. In periodic mode the hardware adds the last period written by software to the target on every match, and a read returns the next match point. A self-clearing value-set bit lets software load the target and the period together, so it can resynchronise a periodic channel after it rewrites the counter. Channel 0 can compare all 64 bits. Its target is then written as a low word, which is held aside, followed by a high word, which commits both halves at once. Channels 1 and 2 compare only the low 32 bits of the counter.

Register map (byte addresses): 0x00 control (bit 0 = run), 0x04 status (bit n = channel n, write 1 to clear), 0x08 counter low word, 0x0C counter high word. Channel n sits at 0x20 + 0x10*n: +0x0 configuration (bit 0 = interrupt enable, bit 1 = periodic, bit 2 = value-set, bit 3 = 64-bit compare), +0x4 comparator low word, +0x8 comparator high word (channel 0 only). Unmapped addresses read 0.

Top module: `evtmr_top`

## Requirements
- R1: While the run bit (control bit 0) is 1, the counter increases by exactly 1 for each rising clock edge at which `tick` is 1. It holds its value when `tick` is 0 or when run is 0.
- R2: The counter words at 0x08 and 0x0C are loaded by a write only while run is 0. A write while run is 1 leaves the counter unchanged.
- R3: On each counter advance, the counter value before the increment is compared with the channel target. When they are equal, the channel status bit becomes 1 at that edge. In one-shot mode (configuration bit 1 = 0) the hardware never alters the target, so the channel matches again whenever the counter later reaches the same value.
- R4: In periodic mode (configuration bit 1 = 1), a match also replaces the target with target plus the stored period. A read of the comparator returns this next target.
- R5: A comparator write to a periodic channel whose value-set bit is 0 stores a new period only. The current target does not move, and the new period is used at the next match.
- R6: When the value-set bit (configuration bit 2) is 1, the next comparator commit loads the written value into both the target and the period. The value-set bit then reads 0.
- R7: Channel 0 resets with 64-bit compare (configuration bit 3 = 1). In that mode a low-word write (0x24) does not change the target. The following high-word write (0x28) commits {high, low} as one value, and the match needs all 64 bits to be equal.
- R8: With 32-bit compare, a channel matches on the low 32 bits of the counter only, and a periodic reload wraps modulo 2^32. Channels 1 and 2 always compare at 32 bits and read configuration bit 3 as 0.
- R9: Writing 1 to status bit n clears channel n's status. A match in the same cycle wins over the clear. `irq[n]` is 1 exactly when status n and the channel's interrupt enable (configuration bit 0) are both 1.
- R10: After reset the counter is 0, run is 0, all status bits and interrupts are 0, channel 0 configuration reads 0x8, and channels 1 and 2 read 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Counter advance enable, sampled each clock |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq | output | 3 | Per-channel interrupt, status AND enable |

## Verification
The hardest states to reach from the ports are a one-shot match that repeats after the counter wraps, and a periodic reload that wraps at 32 bits. Reaching either by counting would take about 2^32 ticks. The bench instead halts the counter and writes it to a value just below the point of interest: a counter whose high word has been stepped past the first match, or a low word near 0xFFFFFFF0. It then releases an exact number of ticks. The same halted-write approach separates a 64-bit match from a low-word-only match on channel 0, by placing the counter at equal low words with different high words.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

  // Register byte addresses
  localparam int ADR_GCTL    = 'h00;
  localparam int ADR_ISTAT   = 'h04;
  localparam int ADR_CNTL    = 'h08;
  localparam int ADR_CNTH    = 'h0C;
  localparam int ADR_CH_BASE = 'h20;
  localparam int CH_STRIDE   = 'h10;
  localparam int OFS_CFG     = 'h0;
  localparam int OFS_CMPL    = 'h4;
  localparam int OFS_CMPH    = 'h8;

  // Channel configuration word, bit 3 down to bit 0
  typedef struct packed {
    logic wide;   // bit 3: 64-bit compare
    logic vset;   // bit 2: direct load of target and period
    logic per;    // bit 1: periodic mode
    logic ie;     // bit 0: interrupt enable
  } chcfg_t;

endpackage

// File: rtl/evtmr_rstsync.sv
module evtmr_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/evtmr_counter.sv
module evtmr_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run_we,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic [DW-1:0] wdata,
  output logic          run_o,
  output logic          adv_o,
  output logic [2*DW-1:0] cnt_o
);

  localparam int CW = 2 * DW;

  logic          run_q, run_d, run_en;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    run_en = run_we;
    run_d  = wdata[0];
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (run_q) begin
      if (tick) begin
        cnt_d  = cnt_q + CW'(1);
        cnt_en = 1'b1;
      end
    end else if (lo_we) begin
      cnt_d  = {cnt_q[CW-1:DW], wdata};
      cnt_en = 1'b1;
    end else if (hi_we) begin
      cnt_d  = {wdata, cnt_q[DW-1:0]};
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (run_en) run_q <= run_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign run_o = run_q;
  assign adv_o = run_q & tick;
  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick) |=> cnt_q == $past(cnt_q) + CW'(1)); // R1
  AST_CNT_IDLE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !lo_we && !hi_we) |=> $stable(cnt_q)); // R1
  AST_CNT_WR_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/evtmr_chan.sv
module evtmr_chan
  import evtmr_pkg::*;
#(
  parameter int DW      = 32,
  parameter bit WIDE_OK = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] cnt,
  input  logic            adv,
  input  logic            cfg_we,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic [DW-1:0]   wdata,
  input  logic            sts_clr,
  output chcfg_t          cfg_o,
  output logic [2*DW-1:0] tgt_o,
  output logic            sts_o,
  output logic            irq_o
);

  localparam int CW = 2 * DW;
  localparam chcfg_t CFG_RST = '{wide: WIDE_OK, vset: 1'b0, per: 1'b0, ie: 1'b0};

  chcfg_t        cfg_q, cfg_d;
  logic          cfg_en;
  logic [CW-1:0] tgt_q, tgt_d, per_q, per_d;
  logic          tgt_en, per_en;
  logic [DW-1:0] stg_q;
  logic          stg_en;
  logic          sts_q, sts_d;
  logic          hit, commit;
  logic [CW-1:0] newv, reload;

  // match and write decode
  always_comb begin
    if (cfg_q.wide) begin
      hit    = adv && (cnt == tgt_q);
      reload = tgt_q + per_q;
      newv   = {wdata, stg_q};
    end else begin
      hit    = adv && (cnt[DW-1:0] == tgt_q[DW-1:0]);
      reload = {{DW{1'b0}}, tgt_q[DW-1:0] + per_q[DW-1:0]};
      newv   = {{DW{1'b0}}, wdata};
    end
    commit = (lo_we && !cfg_q.wide) || (hi_we && cfg_q.wide);
    stg_en = lo_we && cfg_q.wide;
  end

  // next state
  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    tgt_d  = tgt_q;
    tgt_en = 1'b0;
    per_d  = per_q;
    per_en = 1'b0;
    sts_d  = sts_q;

    if (hit && cfg_q.per) begin
      tgt_d  = reload;
      tgt_en = 1'b1;
    end
    if (commit) begin
      per_d  = newv;
      per_en = 1'b1;
      if (cfg_q.vset || !cfg_q.per) begin
        tgt_d  = newv;
        tgt_en = 1'b1;
      end
      cfg_d.vset = 1'b0;
      cfg_en     = 1'b1;
    end
    if (cfg_we) begin
      cfg_d.wide = WIDE_OK ? wdata[3] : 1'b0;
      cfg_d.vset = wdata[2];
      cfg_d.per  = wdata[1];
      cfg_d.ie   = wdata[0];
      cfg_en     = 1'b1;
    end
    if (sts_clr) sts_d = 1'b0;
    if (hit)     sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      tgt_q <= '0;
      per_q <= '0;
      stg_q <= '0;
      sts_q <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      if (tgt_en) tgt_q <= tgt_d;
      if (per_en) per_q <= per_d;
      if (stg_en) stg_q <= wdata;
      sts_q <= sts_d;
    end
  end

  assign cfg_o = cfg_q;
  assign tgt_o = tgt_q;
  assign sts_o = sts_q;
  assign irq_o = sts_q & cfg_q.ie;

  AST_STS_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> sts_q); // R3
  AST_ONESHOT_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.per && !commit) |=> tgt_q == $past(tgt_q)); // R3
  AST_PER_RELOAD_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg_q.per && cfg_q.wide && !commit) |=> tgt_q == $past(tgt_q) + $past(per_q)); // R4
  AST_PER_WR_KEEPS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cfg_q.per && !cfg_q.vset && !hit) |=> $stable(tgt_q)); // R5
  AST_VSET_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !cfg_q.vset); // R6
  AST_LOW_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && cfg_q.wide && !hit) |=> $stable(tgt_q)); // R7
  AST_NARROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg_q.per && !cfg_q.wide && !commit)
      |=> tgt_q[DW-1:0] == $past(tgt_q[DW-1:0]) + $past(per_q[DW-1:0])); // R8
  AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !hit) |=> !sts_q); // R9

endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
  import evtmr_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NCH = 3,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq
);

  localparam int CW = 2 * DW;

  function automatic logic [AW-1:0] ch_adr(input int ch, input int ofs);
    return AW'(ADR_CH_BASE + ch * CH_STRIDE + ofs);
  endfunction

  logic          rst_sync_n;
  logic          run, adv;
  logic [CW-1:0] cnt;

  chcfg_t        cfg_a [NCH];
  logic [CW-1:0] tgt_a [NCH];
  logic [NCH-1:0] sts_v;

  evtmr_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  evtmr_counter #(.DW(DW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick),
    .run_we (bus_we && bus_addr == AW'(ADR_GCTL)),
    .lo_we  (bus_we && bus_addr == AW'(ADR_CNTL)),
    .hi_we  (bus_we && bus_addr == AW'(ADR_CNTH)),
    .wdata  (bus_wdata),
    .run_o  (run),
    .adv_o  (adv),
    .cnt_o  (cnt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    evtmr_chan #(.DW(DW), .WIDE_OK(g == 0)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .cnt     (cnt),
      .adv     (adv),
      .cfg_we  (bus_we && bus_addr == ch_adr(g, OFS_CFG)),
      .lo_we   (bus_we && bus_addr == ch_adr(g, OFS_CMPL)),
      .hi_we   (bus_we && (g == 0) && bus_addr == ch_adr(g, OFS_CMPH)),
      .wdata   (bus_wdata),
      .sts_clr (bus_we && bus_addr == AW'(ADR_ISTAT) && bus_wdata[g]),
      .cfg_o   (cfg_a[g]),
      .tgt_o   (tgt_a[g]),
      .sts_o   (sts_v[g]),
      .irq_o   (irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADR_GCTL))  bus_rdata = DW'(run);
    if (bus_addr == AW'(ADR_ISTAT)) bus_rdata = DW'(sts_v);
    if (bus_addr == AW'(ADR_CNTL))  bus_rdata = cnt[DW-1:0];
    if (bus_addr == AW'(ADR_CNTH))  bus_rdata = cnt[CW-1:DW];
    for (int g = 0; g < NCH; g++) begin
      if (bus_addr == ch_adr(g, OFS_CFG))  bus_rdata = DW'(cfg_a[g]);
      if (bus_addr == ch_adr(g, OFS_CMPL)) bus_rdata = tgt_a[g][DW-1:0];
      if (g == 0 && bus_addr == ch_adr(g, OFS_CMPH)) bus_rdata = tgt_a[g][CW-1:DW];
    end
  end

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq & ~sts_v) == '0); // R9

endmodule

// File: tb/evtmr_top_tb_top.sv
`timescale 1ns/1ps
module evtmr_top_tb_top;

  localparam logic [7:0] A_GCTL = 8'h00, A_ISTAT = 8'h04, A_CNTL = 8'h08, A_CNTH = 8'h0C;
  localparam logic [7:0] A_CFG0 = 8'h20, A_CMPL0 = 8'h24, A_CMPH0 = 8'h28;
  localparam logic [7:0] A_CFG1 = 8'h30, A_CMPL1 = 8'h34;
  localparam logic [7:0] A_CFG2 = 8'h40, A_CMPL2 = 8'h44;
  localparam logic [7:0] A_IRQ  = 8'hFF; // marks a check of the irq port

  logic        clk = 1'b0;
  logic        rst_n, tick, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] e;
    string       tag;
  } item_t;

  item_t sb[$];
  event  sb_ev;

  always #5 clk = ~clk;

  evtmr_top dut_i (
    .clk (clk), .rst_n (rst_n), .tick (tick), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq)
  );

  // monitor: pops expected items and compares with what the design shows
  initial begin
    forever begin
      @(sb_ev);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = (it.a == A_IRQ) ? {29'b0, irq} : bus_rdata;
        vectors++;
        if (act !== it.e) begin
          miscompares++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, act, it.e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    if (a != A_IRQ) bus_addr = a;
    sb.push_back('{a: a, e: e, tag: tag});
    ->sb_ev;
  endtask

  task automatic setcnt(input logic [31:0] hi, input logic [31:0] lo);
    wr(A_GCTL, 32'h0);
    wr(A_CNTL, lo);
    wr(A_CNTH, hi);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk(A_GCTL, 32'h0, "R10 run");
    chk(A_CNTL, 32'h0, "R10 cnt lo");
    chk(A_CNTH, 32'h0, "R10 cnt hi");
    chk(A_CFG0, 32'h8, "R10 cfg0");
    chk(A_CFG1, 32'h0, "R10 cfg1");
    chk(A_CFG2, 32'h0, "R10 cfg2");
    chk(A_ISTAT, 32'h0, "R10 status");
    chk(A_IRQ, 32'h0, "R10 irq");

    // R1 counting per tick
    wr(A_GCTL, 32'h1);
    ticks(10);
    chk(A_CNTL, 32'd10, "R1 ten ticks");
    repeat (3) @(negedge clk);
    chk(A_CNTL, 32'd10, "R1 hold without tick");

    // R2 counter writes only when halted
    wr(A_CNTL, 32'h1234);
    chk(A_CNTL, 32'd10, "R2 write while running ignored");
    wr(A_GCTL, 32'h0);
    wr(A_CNTL, 32'd5);
    chk(A_CNTL, 32'd5, "R2 low write halted");
    wr(A_CNTH, 32'd7);
    chk(A_CNTH, 32'd7, "R2 high write halted");

    // R3 one-shot on channel 1
    wr(A_CFG1, 32'h1);
    wr(A_CMPL1, 32'h20);
    setcnt(0, 0);
    wr(A_GCTL, 32'h1);
    ticks(1);
    wr(A_ISTAT, 32'h7);
    ticks(31);
    chk(A_ISTAT, 32'h0, "R3 no match before target");
    chk(A_IRQ, 32'h0, "R3 irq idle");
    ticks(1);
    chk(A_IRQ, 32'h2, "R3 match irq");
    chk(A_ISTAT, 32'h2, "R3 status set");
    chk(A_CMPL1, 32'h20, "R3 target unchanged");
    chk(A_CNTL, 32'h21, "R1 count after match");

    // R9 enable gating and write-1-to-clear
    wr(A_CFG1, 32'h0);
    chk(A_IRQ, 32'h0, "R9 irq masked");
    chk(A_ISTAT, 32'h2, "R9 status kept when masked");
    wr(A_CFG1, 32'h1);
    wr(A_ISTAT, 32'h2);
    chk(A_ISTAT, 32'h0, "R9 cleared by write 1");
    chk(A_IRQ, 32'h0, "R9 irq after clear");

    // R3 match again after a wrap of the low word
    setcnt(1, 32'h1F);
    wr(A_GCTL, 32'h1);
    ticks(1);
    chk(A_ISTAT, 32'h0, "R3 one before rematch");
    ticks(1);
    chk(A_IRQ, 32'h2, "R3 rematch after wrap");
    wr(A_ISTAT, 32'h7);

    // R6 / R4 periodic on channel 2
    setcnt(0, 0);
    wr(A_CFG2, 32'h7);
    wr(A_CMPL2, 32'h10);
    chk(A_CFG2, 32'h3, "R6 value-set self clears");
    chk(A_CMPL2, 32'h10, "R6 target loaded");
    wr(A_GCTL, 32'h1);
    ticks(1);
    wr(A_ISTAT, 32'h7);
    ticks(16);
    chk(A_CMPL2, 32'h20, "R4 reload after match");
    chk(A_IRQ, 32'h4, "R4 periodic irq");
    wr(A_ISTAT, 32'h4);

    // R5 new period does not move target
    wr(A_CMPL2, 32'h8);
    chk(A_CMPL2, 32'h20, "R5 target kept on period write");
    ticks(16);
    chk(A_IRQ, 32'h6, "R4 match at old target");
    chk(A_CMPL2, 32'h28, "R5 new period applied");
    ticks(8);
    chk(A_CMPL2, 32'h30, "R4 second periodic reload");

    // R6 resynchronise after counter reset
    setcnt(0, 0);
    wr(A_CFG2, 32'h7);
    wr(A_CMPL2, 32'h5);
    chk(A_CMPL2, 32'h5, "R6 direct target load");
    chk(A_CFG2, 32'h3, "R6 bit clear again");
    wr(A_GCTL, 32'h1);
    ticks(1);
    wr(A_ISTAT, 32'h7);
    ticks(5);
    chk(A_ISTAT, 32'h4, "R6 match at loaded target");
    chk(A_CMPL2, 32'hA, "R6 loaded period used");

    // R8 32-bit periodic wrap
    setcnt(0, 32'hFFFF_FFF0);
    wr(A_CFG2, 32'h7);
    wr(A_CMPL2, 32'hFFFF_FFF8);
    wr(A_ISTAT, 32'h7);
    wr(A_GCTL, 32'h1);
    ticks(9);
    chk(A_ISTAT, 32'h4, "R8 match near top");
    chk(A_CMPL2, 32'hFFFF_FFF0, "R8 reload wraps mod 2^32");
    wr(A_CFG1, 32'h9);
    chk(A_CFG1, 32'h1, "R8 channel 1 has no 64-bit mode");
    wr(A_CFG1, 32'h1);

    // R7 channel 0 split 64-bit write and full compare
    wr(A_GCTL, 32'h0);
    wr(A_CFG0, 32'h9);
    wr(A_CMPL0, 32'h3);
    chk(A_CMPL0, 32'h0, "R7 low word staged only");
    wr(A_CMPH0, 32'h1);
    chk(A_CMPL0, 32'h3, "R7 low committed with high");
    chk(A_CMPH0, 32'h1, "R7 high word");
    setcnt(0, 32'h2);
    wr(A_ISTAT, 32'h7);
    wr(A_GCTL, 32'h1);
    ticks(3);
    chk(A_ISTAT, 32'h0, "R7 low-only equality no match");
    setcnt(1, 32'h2);
    wr(A_ISTAT, 32'h7);
    wr(A_GCTL, 32'h1);
    ticks(2);
    chk(A_IRQ, 32'h1, "R7 full 64-bit match");

    // R8 channel 0 in 32-bit mode
    wr(A_GCTL, 32'h0);
    wr(A_CFG0, 32'h1);
    wr(A_CMPL0, 32'h7);
    chk(A_CMPL0, 32'h7, "R8 narrow direct commit");
    chk(A_CMPH0, 32'h0, "R8 narrow upper zero");
    setcnt(5, 32'h6);
    wr(A_ISTAT, 32'h7);
    wr(A_GCTL, 32'h1);
    ticks(2);
    chk(A_ISTAT, 32'h1, "R8 low-word match ignores high");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule